// File: doc/BRIEF.md
# Audio Frame and Bit Clock Master with Power-Up Straps

This block is the clock-master end of a serial audio port. It takes an incoming master clock and produces a frame clock and a bit clock on two bidirectional pads. Right after reset the two pads have not yet become outputs. Their levels are read once as configuration straps: the frame pad selects the speed mode and the bit pad selects the base clock ratio. After a short settling delay the block enables both pad drivers and runs the two dividers from a known phase.

A prescale enable, captured on the same edge as the straps, marks that the master clock runs at twice the nominal rate. When it is set, every divide ratio doubles. The configuration is frozen until the next reset, so later activity on the pads cannot disturb the clocks.

Top module: `aclk_master_gen`

## Requirements
- R1: From reset until the 20th rising master-clock edge after reset release, both output enables and both pad outputs are 0. On that 20th edge (capture edge plus 4) both enables go to 1 together.
- R2: The strap inputs and the prescale enable are captured on the 16th rising edge after reset release. Values present before or after that edge have no effect.
- R3: A frame-pad strap of 0 selects single speed and 1 selects double speed. Double speed halves the bit-clock divisor (4 becomes 2, 6 becomes 3).
- R4: A bit-pad strap of 0 selects the 256x frame ratio, which is a bit-clock divisor of 4 in single speed. A strap of 1 selects 384x, which is a divisor of 6.
- R5: A captured prescale enable of 1 doubles the bit-clock period in master-clock cycles: 8, 12, 4 or 6 for the four strap cases.
- R6: With divisor D and prescale factor s (1 or 2), the bit clock starts low on the enable edge. Each period is D*s cycles: low for ceil(D/2)*s cycles, then high for floor(D/2)*s cycles. For D=3 the high time is s cycles, which is at least one master-clock cycle.
- R7: The frame clock lasts 64 bit-clock periods. It starts low on the enable edge, stays low for the first 32 periods (left channel) and is high for the next 32.
- R8: The frame clock changes only on a master-clock edge where the bit clock falls.
- R9: Once the enables are set, the captured configuration holds until the next reset, and pad or prescale input changes do not alter the clocks. A new reset captures the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_en_i | input | 1 | Master clock runs at twice the rate; captured with the straps |
| fs_pin_i | input | 1 | Sampled level of the frame-clock pad (speed strap) |
| bc_pin_i | input | 1 | Sampled level of the bit-clock pad (ratio strap) |
| fs_pin_o | output | 1 | Frame-clock pad output value |
| fs_pin_oe | output | 1 | Frame-clock pad output enable |
| bc_pin_o | output | 1 | Bit-clock pad output value |
| bc_pin_oe | output | 1 | Bit-clock pad output enable |

## Verification
The bench uses the default parameters: capture on edge 16, enable four edges later, base divisors 4 and 6, and 64 bit periods per frame. With these values the longest frame is 768 cycles, so two complete frames can be compared cycle by cycle for all eight strap and prescale combinations. The odd divisor 3 is exercised with and without the prescaler. Because the capture point and the enable delay are short, the bench can move strap levels to the edges around the capture edge and confirm that only edge 16 counts.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef struct packed {
        logic dbl_speed;   // frame-pad strap: 1 = double speed
        logic wide_ratio;  // bit-pad strap: 1 = 384x base ratio
        logic prescale;    // master clock runs at twice the rate
    } clk_cfg_t;

endpackage

// File: rtl/aclk_strap_ctl.sv
module aclk_strap_ctl
    import aclk_pkg::*;
#(
    parameter int CAPTURE_CYC = 16,
    parameter int OE_DELAY    = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fs_strap_i,
    input  logic     bc_strap_i,
    input  logic     prescale_i,
    output clk_cfg_t cfg_o,
    output logic     run_o
);

    localparam int DONE_CYC = CAPTURE_CYC + OE_DELAY;
    localparam int TW       = $clog2(DONE_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] timer;
        clk_cfg_t      cfg;
        logic          oe;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.oe) begin
            st_d.timer = st_q.timer + 1'b1;
            if (st_q.timer == TW'(CAPTURE_CYC - 1)) begin
                st_d.cfg.dbl_speed  = fs_strap_i;
                st_d.cfg.wide_ratio = bc_strap_i;
                st_d.cfg.prescale   = prescale_i;
            end
            if (st_q.timer == TW'(DONE_CYC - 1)) begin
                st_d.oe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign run_o = st_q.oe;

endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div
    import aclk_pkg::*;
#(
    parameter int DIV_NARROW = 4,
    parameter int DIV_WIDE   = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  clk_cfg_t cfg_i,
    output logic     bclk_o,
    output logic     wrap_o
);

    localparam int DW = $clog2(DIV_WIDE + 1);

    typedef struct packed {
        logic [DW-1:0] phase;
        logic          half;
        logic          lvl;
    } bit_st_t;

    bit_st_t       bd_d, bd_q;
    logic [DW-1:0] div_full;
    logic [DW-1:0] div_eff;
    logic [DW-1:0] low_len;
    logic          tick;
    logic          wrap;

    assign div_full = cfg_i.wide_ratio ? DW'(DIV_WIDE) : DW'(DIV_NARROW);
    assign div_eff  = cfg_i.dbl_speed ? (div_full >> 1) : div_full;
    assign low_len  = (div_eff >> 1) + DW'(div_eff[0]);

    always_comb begin
        bd_d = bd_q;
        tick = 1'b0;
        wrap = 1'b0;
        if (run_i) begin
            tick      = !cfg_i.prescale || bd_q.half;
            bd_d.half = cfg_i.prescale & ~bd_q.half;
            if (tick) begin
                if (bd_q.phase == div_eff - 1'b1) begin
                    bd_d.phase = '0;
                    wrap       = 1'b1;
                end else begin
                    bd_d.phase = bd_q.phase + 1'b1;
                end
            end
            bd_d.lvl = (bd_d.phase >= low_len);
        end else begin
            bd_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bd_q <= '0;
        end else begin
            bd_q <= bd_d;
        end
    end

    assign bclk_o = bd_q.lvl;
    assign wrap_o = wrap;

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic wrap_i,
    output logic fclk_o
);

    localparam int BW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [BW-1:0] slot;
        logic          lvl;
    } frame_st_t;

    frame_st_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (!run_i) begin
            fr_d = '0;
        end else if (wrap_i) begin
            fr_d.slot = (fr_q.slot == BW'(FRAME_BITS - 1)) ? '0 : fr_q.slot + 1'b1;
            fr_d.lvl  = (fr_d.slot >= BW'(FRAME_BITS / 2));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign fclk_o = fr_q.lvl;

endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen
    import aclk_pkg::*;
#(
    parameter int CAPTURE_CYC = 16,
    parameter int OE_DELAY    = 4,
    parameter int DIV_NARROW  = 4,
    parameter int DIV_WIDE    = 6,
    parameter int FRAME_BITS  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prescale_en_i,
    input  logic fs_pin_i,
    input  logic bc_pin_i,
    output logic fs_pin_o,
    output logic fs_pin_oe,
    output logic bc_pin_o,
    output logic bc_pin_oe
);

    clk_cfg_t cfg;
    logic     run;
    logic     bclk;
    logic     wrap;
    logic     fclk;

    aclk_strap_ctl #(
        .CAPTURE_CYC(CAPTURE_CYC),
        .OE_DELAY   (OE_DELAY)
    ) u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_strap_i(fs_pin_i),
        .bc_strap_i(bc_pin_i),
        .prescale_i(prescale_en_i),
        .cfg_o     (cfg),
        .run_o     (run)
    );

    aclk_bit_div #(
        .DIV_NARROW(DIV_NARROW),
        .DIV_WIDE  (DIV_WIDE)
    ) u_bit (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .cfg_i (cfg),
        .bclk_o(bclk),
        .wrap_o(wrap)
    );

    aclk_frame_div #(
        .FRAME_BITS(FRAME_BITS)
    ) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .wrap_i(wrap),
        .fclk_o(fclk)
    );

    assign fs_pin_o  = fclk;
    assign bc_pin_o  = bclk;
    assign fs_pin_oe = run;
    assign bc_pin_oe = run;

endmodule

// File: rtl/aclk_master_gen_chk.sv
module aclk_master_gen_chk
    import aclk_pkg::*;
#(
    parameter int CAPTURE_CYC = 16,
    parameter int OE_DELAY    = 4
) (
    input logic     clk,
    input logic     rst_n,
    input logic     fs_pin_o,
    input logic     fs_pin_oe,
    input logic     bc_pin_o,
    input logic     bc_pin_oe,
    input clk_cfg_t cfg
);

    localparam int DONE_CYC = CAPTURE_CYC + OE_DELAY;
    localparam int CW       = $clog2(DONE_CYC + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(DONE_CYC + 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_OE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_pin_oe) |-> (cnt_q == CW'(DONE_CYC)));  // R1
    AST_QUIET_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_pin_oe |-> (!fs_pin_o && !bc_pin_o));  // R1
    AST_OE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        fs_pin_oe == bc_pin_oe);  // R1
    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fs_pin_oe |=> fs_pin_oe);  // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fs_pin_oe |=> $stable(cfg));  // R9
    AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fs_pin_o) |-> $fell(bc_pin_o));  // R8

endmodule

bind aclk_master_gen aclk_master_gen_chk #(
    .CAPTURE_CYC(CAPTURE_CYC),
    .OE_DELAY   (OE_DELAY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_pin_o (fs_pin_o),
    .fs_pin_oe(fs_pin_oe),
    .bc_pin_o (bc_pin_o),
    .bc_pin_oe(bc_pin_oe),
    .cfg      (cfg)
);

// File: tb/aclk_master_gen_test.sv
module aclk_master_gen_test;

    logic clk    = 1'b0;
    logic rst_n  = 1'b0;
    logic fs_in  = 1'b0;
    logic bc_in  = 1'b0;
    logic pre_in = 1'b0;
    logic fs_o, fs_oe, bc_o, bc_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    aclk_master_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .prescale_en_i(pre_in),
        .fs_pin_i     (fs_in),
        .bc_pin_i     (bc_in),
        .fs_pin_o     (fs_o),
        .fs_pin_oe    (fs_oe),
        .bc_pin_o     (bc_o),
        .bc_pin_oe    (bc_oe)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reset with {fs, bc, pre} straps applied; release on a falling edge.
    task automatic do_reset(logic [2:0] v);
        rst_n = 1'b0;
        {fs_in, bc_in, pre_in} = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs edges 1..20 after release, applying up to two input changes
    // right after the given edges; checks the enable timing (R1).
    task automatic power_up(int ea, logic [2:0] va, int eb, logic [2:0] vb);
        int first_oe = -1;
        int noisy    = 0;
        for (int e = 1; e <= 20; e++) begin
            @(posedge clk);
            @(negedge clk);
            if ((fs_oe || bc_oe) && first_oe < 0) first_oe = e;
            if (!fs_oe && (fs_o || bc_o)) noisy++;
            if (e == ea) {fs_in, bc_in, pre_in} = va;
            if (e == eb) {fs_in, bc_in, pre_in} = vb;
        end
        chk(first_oe == 20 && fs_oe && bc_oe, "R1", "first enable edge", first_oe, 20);
        chk(noisy == 0, "R1", "pad outputs active before enable", noisy, 0);
    endtask

    // Compares two frames against the expected waveforms; k=0 is the enable edge.
    task automatic check_wave(int d, int s, bit wiggle, string req);
        int nc     = 2 * 64 * d * s;
        int bad_b  = 0;
        int bad_f  = 0;
        int bad_al = 0;
        int rise_k = -1;
        int period = -1;
        int hi_run = 0;
        int min_hi = 100000;
        logic pb = 1'b0;
        logic pf = 1'b0;
        logic eb, ef;
        for (int k = 0; k < nc; k++) begin
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            if (wiggle) begin
                fs_in  = k[0];
                bc_in  = k[1];
                pre_in = k[2];
            end
            eb = (((k / s) % d) >= ((d + 1) / 2));
            ef = ((((k / s) / d) % 64) >= 32);
            if (bc_o !== eb) bad_b++;
            if (fs_o !== ef) bad_f++;
            if (k > 0 && fs_o !== pf && !(pb && !bc_o)) bad_al++;
            if (bc_o) hi_run++;
            if (!bc_o && pb) begin
                if (hi_run < min_hi) min_hi = hi_run;
                hi_run = 0;
            end
            if (bc_o && !pb) begin
                if (rise_k >= 0) period = k - rise_k;
                rise_k = k;
            end
            pb = bc_o;
            pf = fs_o;
        end
        chk(bad_b == 0, req, "bit clock waveform mismatches", bad_b, 0);
        chk(period == d * s, req, "bit clock period", period, d * s);
        chk(min_hi == (d / 2) * s, "R6", "bit clock high time", min_hi, (d / 2) * s);
        chk(bad_f == 0, "R7", "frame clock waveform mismatches", bad_f, 0);
        chk(bad_al == 0, "R8", "frame changes off a bit clock fall", bad_al, 0);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        {fs_in, bc_in, pre_in} = 3'b111;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!fs_oe && !bc_oe, "R1", "enables during reset", int'({fs_oe, bc_oe}), 0);
        chk(!fs_o && !bc_o, "R1", "pad outputs during reset", int'({fs_o, bc_o}), 0);
    endtask

    task automatic t_config(logic [2:0] v, string req);
        int base = v[1] ? 6 : 4;
        int d    = v[2] ? base / 2 : base;
        int s    = v[0] ? 2 : 1;
        do_reset(v);
        power_up(0, 3'b000, 0, 3'b000);
        check_wave(d, s, 1'b0, req);
    endtask

    // R2: only the level present at edge 16 is captured.
    task automatic t_capture_edge();
        do_reset(3'b000);
        power_up(15, 3'b110, 16, 3'b001);
        check_wave(3, 1, 1'b0, "R2");
        do_reset(3'b000);
        power_up(16, 3'b111, 0, 3'b000);
        check_wave(4, 1, 1'b0, "R2");
    endtask

    // R9: pad changes after enable are ignored; a new reset recaptures.
    task automatic t_hold_and_recapture();
        do_reset(3'b010);
        power_up(0, 3'b000, 0, 3'b000);
        check_wave(6, 1, 1'b1, "R9");
        do_reset(3'b100);
        power_up(0, 3'b000, 0, 3'b000);
        check_wave(2, 1, 1'b0, "R9");
    endtask

    initial begin
        t_reset_state();
        t_config(3'b000, "R4");
        t_config(3'b010, "R4");
        t_config(3'b100, "R3");
        t_config(3'b110, "R3");
        t_config(3'b001, "R5");
        t_config(3'b011, "R5");
        t_config(3'b101, "R5");
        t_config(3'b111, "R5");
        t_capture_edge();
        t_hold_and_recapture();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule